// File: doc/BRIEF.md
# Wake-Up and Duty-Cycle Timer

This block raises a periodic wake event from a slow millisecond tick. The period is a product of an 8-bit mantissa and a power of two set by a 5-bit exponent. The timer splits the period into base units of 2^exponent ticks and counts mantissa base units per period. Configuration arrives as 16-bit command words with a write strobe. The block decodes two kinds of word, one for the period and one for a low-duty-cycle mode, and ignores every other word.

A rising edge on the enable input starts a fresh period. The block then issues one-cycle wake pulses for as long as the enable stays high. Period changes written while the timer runs take effect only at the next period boundary. When low-duty-cycle mode is on, a receiver-enable output goes high at the start of every period and stays high for (2·D+1) base units. Every wake event sets a sticky overflow flag, and a status-read pulse clears it.

Top module: `wdt_top`

## Requirements
- R1: A strobed word whose bits 15..13 are 111 loads the exponent from bits 12..8 and the mantissa from bits 7..0. A strobed word whose bits 15..8 equal C8h loads the on-code D from bits 7..1 and the duty-mode enable from bit 0. Any other word changes nothing.
- R2: After reset, wake_o, ovf_o and rx_en_o are low. The mantissa is 150, the exponent is 1 and the duty mode is off (word values E196h and C80Eh).
- R3: wake_o is a one-cycle pulse in the clock after a tick. The first pulse follows the M·2^R-th tick after the enable rises, and later pulses follow every further M·2^R ticks.
- R4: A rising edge on run_en_i restarts the period phase from zero. While run_en_i is low, no wake pulse occurs and rx_en_o stays low.
- R5: Exponent and mantissa writes made while the timer runs first apply to the period that starts after the next wake pulse.
- R6: An active mantissa of 0 produces no wake pulse and keeps rx_en_o low.
- R7: With the duty mode on, rx_en_o is high from the start of each period until 2·D+1 base units of 2^R ticks have elapsed, then low until the next period. If 2·D+1 is at least M, it stays high for the whole period.
- R8: A duty word with bit 0 clear drives rx_en_o low from the clock after the write.
- R9: ovf_o goes high in the clock after a wake pulse and stays high until a stat_rd_i pulse, after which it is low in the next clock. When a wake pulse and a read coincide, ovf_o stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle millisecond tick |
| cmd_i | input | 16 | Command word |
| cmd_we_i | input | 1 | Command write strobe |
| run_en_i | input | 1 | Timer enable; a rising edge re-arms the timer |
| stat_rd_i | input | 1 | Status read completed, one-cycle pulse |
| wake_o | output | 1 | Wake event pulse |
| ovf_o | output | 1 | Sticky wake overflow flag |
| rx_en_o | output | 1 | Duty-cycled receiver enable |

## Verification
The hardest case is a status read that lands in exactly the clock of a wake pulse, because the set and clear paths of the overflow flag then compete. The bench counts ticks and waits for the tick that ends a period. It then drives the read pulse during the following clock, which is the wake cycle. The second hard case is a period change deferred to the boundary. The bench writes a new period in the middle of a run and checks that the wake pulse at the old boundary still arrives on time, and that only the pulses after it follow the new spacing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CMD_W  = 16;
  localparam int MANT_W = 8;
  localparam int EXP_W  = 5;
  localparam int DUTY_W = 7;
  localparam int WAKE_OP_LSB = MANT_W + EXP_W;
  localparam int DUTY_OP_LSB = DUTY_W + 1;
  localparam logic [CMD_W-WAKE_OP_LSB-1:0] WAKE_OP = 3'b111;
  localparam logic [CMD_W-DUTY_OP_LSB-1:0] DUTY_OP = 8'hC8;

  typedef struct packed {
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
  } wake_cfg_t;

  typedef struct packed {
    logic [DUTY_W-1:0] on_code;
    logic              en;
  } duty_cfg_t;
endpackage

// File: rtl/wdt_cmd_dec.sv
module wdt_cmd_dec
  import wdt_pkg::*;
#(
  parameter logic [CMD_W-1:0] WAKE_RST = 16'hE196,
  parameter logic [CMD_W-1:0] DUTY_RST = 16'hC80E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cmd_we_i,
  output wake_cfg_t        wake_cfg_o,
  output duty_cfg_t        duty_cfg_o
);
  logic wake_hit, duty_hit;

  assign wake_hit = cmd_we_i && (cmd_i[CMD_W-1:WAKE_OP_LSB] == WAKE_OP);
  assign duty_hit = cmd_we_i && (cmd_i[CMD_W-1:DUTY_OP_LSB] == DUTY_OP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_cfg_o <= wake_cfg_t'(WAKE_RST[WAKE_OP_LSB-1:0]);
      duty_cfg_o <= duty_cfg_t'(DUTY_RST[DUTY_OP_LSB-1:0]);
    end else begin
      if (wake_hit) wake_cfg_o <= wake_cfg_t'(cmd_i[WAKE_OP_LSB-1:0]);
      if (duty_hit) duty_cfg_o <= duty_cfg_t'(cmd_i[DUTY_OP_LSB-1:0]);
    end
  end

  // R1
  wake_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[CMD_W-1:WAKE_OP_LSB] == WAKE_OP) |=>
      (wake_cfg_o == $past(cmd_i[WAKE_OP_LSB-1:0])));
  // R1
  other_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_we_i || (cmd_i[CMD_W-1:WAKE_OP_LSB] != WAKE_OP &&
                   cmd_i[CMD_W-1:DUTY_OP_LSB] != DUTY_OP)) |=>
      ($stable(wake_cfg_o) && $stable(duty_cfg_o)));
endmodule

// File: rtl/wdt_period_gen.sv
module wdt_period_gen
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_en_i,
  input  wake_cfg_t         cfg_i,
  output logic              wake_o,
  output logic              run_o,
  output logic              mant_nz_o,
  output logic [MANT_W-1:0] unit_idx_o
);
  localparam int PRE_W = 1 << EXP_W;
  localparam int IW    = EXP_W + 1;

  logic              run_q;
  logic [PRE_W-1:0]  pre_cnt, pre_lim;
  logic [MANT_W-1:0] unit_cnt;
  wake_cfg_t         act;
  logic              pre_last, unit_last;

  // base unit is 2^expo ticks: terminal value has the low expo bits set
  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_lim[i] = (IW'(i) < IW'(act.expo));
  end

  assign pre_last  = (pre_cnt == pre_lim);
  assign unit_last = (unit_cnt == act.mant - MANT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pre_cnt  <= '0;
      unit_cnt <= '0;
      act      <= '0;
      wake_o   <= 1'b0;
    end else begin
      run_q  <= run_en_i;
      wake_o <= 1'b0;
      if (run_en_i && !run_q) begin
        act      <= cfg_i;
        pre_cnt  <= '0;
        unit_cnt <= '0;
      end else if (run_en_i && tick_i && act.mant != '0) begin
        if (pre_last) begin
          pre_cnt <= '0;
          if (unit_last) begin
            unit_cnt <= '0;
            wake_o   <= 1'b1;
            act      <= cfg_i;   // new period takes the pending setting
          end else begin
            unit_cnt <= unit_cnt + MANT_W'(1);
          end
        end else begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
      end
    end
  end

  assign run_o      = run_q;
  assign mant_nz_o  = (act.mant != '0);
  assign unit_idx_o = unit_cnt;

  // R3
  wake_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(tick_i));
  // R4
  no_wake_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> !wake_o);
  // R6
  zero_mant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act.mant == '0) |=> !wake_o);
endmodule

// File: rtl/wdt_duty_gen.sv
module wdt_duty_gen
  import wdt_pkg::*;
(
  input  duty_cfg_t         cfg_i,
  input  logic              run_i,
  input  logic              mant_nz_i,
  input  logic [MANT_W-1:0] unit_idx_i,
  output logic              rx_en_o
);
  localparam int CW = (MANT_W > DUTY_W + 1) ? MANT_W : DUTY_W + 1;

  logic [CW-1:0] on_units, idx_ext;

  assign on_units = CW'({cfg_i.on_code, 1'b1});   // 2*D + 1
  assign idx_ext  = CW'(unit_idx_i);
  assign rx_en_o  = cfg_i.en && run_i && mant_nz_i && (idx_ext < on_units);
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  input  logic stat_rd_i,
  output logic ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (wake_i)    ovf_o <= 1'b1;   // a new event beats a read
    else if (stat_rd_i) ovf_o <= 1'b0;
  end

  // R9
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> ovf_o);
  // R9
  ovf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !wake_i) |=> !ovf_o);
  // R9
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !stat_rd_i) |=> ovf_o);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter logic [CMD_W-1:0] WAKE_RST = 16'hE196,
  parameter logic [CMD_W-1:0] DUTY_RST = 16'hC80E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cmd_we_i,
  input  logic             run_en_i,
  input  logic             stat_rd_i,
  output logic             wake_o,
  output logic             ovf_o,
  output logic             rx_en_o
);
  wake_cfg_t         wake_cfg;
  duty_cfg_t         duty_cfg;
  logic              run, mant_nz;
  logic [MANT_W-1:0] unit_idx;

  wdt_cmd_dec #(.WAKE_RST(WAKE_RST), .DUTY_RST(DUTY_RST)) u_dec (
    .clk_i, .rst_ni, .cmd_i, .cmd_we_i,
    .wake_cfg_o(wake_cfg), .duty_cfg_o(duty_cfg)
  );

  wdt_period_gen u_per (
    .clk_i, .rst_ni, .tick_i, .run_en_i,
    .cfg_i(wake_cfg), .wake_o, .run_o(run),
    .mant_nz_o(mant_nz), .unit_idx_o(unit_idx)
  );

  wdt_duty_gen u_duty (
    .cfg_i(duty_cfg), .run_i(run), .mant_nz_i(mant_nz),
    .unit_idx_i(unit_idx), .rx_en_o
  );

  wdt_status u_stat (
    .clk_i, .rst_ni, .wake_i(wake_o), .stat_rd_i, .ovf_o
  );

  // R8
  duty_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[CMD_W-1:DUTY_OP_LSB] == DUTY_OP && !cmd_i[0]) |=> !rx_en_o);
  // R4
  rx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> !rx_en_o);
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] cmd = '0;
  logic        we = 1'b0;
  logic        run_en = 1'b0;
  logic        stat_rd = 1'b0;
  logic        wake, ovf, rx_en;

  int total = 0;
  int bad = 0;
  int tick_n = 0;
  int wake_seen = 0;
  bit done = 0;
  int exp_q[$];

  always #10 clk = ~clk;   // 50 MHz

  wdt_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_i(cmd), .cmd_we_i(we),
    .run_en_i(run_en), .stat_rd_i(stat_rd),
    .wake_o(wake), .ovf_o(ovf), .rx_en_o(rx_en)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator: one pulse every four clocks
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk); tick = 1'b1; tick_n++;
      @(negedge clk); tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  end

  // monitor: every wake pulse pops the expected tick number
  always @(negedge clk) begin
    if (rst_n && wake) begin
      wake_seen++;
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3: actual=unexpected wake at tick %0d expected=none", tick_n);
      end else begin
        check("R3 wake tick", tick_n, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [15:0] w);
    @(negedge clk); cmd = w; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic start(output int base);
    @(negedge tick);
    run_en = 1'b1;
    base = tick_n;
  endtask

  task automatic after_tick(int n);
    wait (tick_n == n);
    @(negedge clk);
  endtask

  task automatic stop(string req);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk);
    check({req, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    int b, b2, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 wake reset", wake, 0);
    check("R2 ovf reset", ovf, 0);
    check("R2 rx_en reset", rx_en, 0);

    // reset period 150 * 2^1, duty off
    start(b);
    exp_q.push_back(b + 300);
    after_tick(b + 300);
    check("R2 duty off at reset", rx_en, 0);
    @(negedge clk);
    check("R9 ovf set", ovf, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check("R9 ovf cleared", ovf, 0);
    stop("R2");

    // period 3 ticks, foreign words ignored
    wr(16'hE003); wr(16'h8208); wr(16'hC000); wr(16'hB8AA);
    start(b);
    exp_q.push_back(b + 3); exp_q.push_back(b + 6); exp_q.push_back(b + 9);
    wait (tick_n == b + 3);
    @(negedge clk); stat_rd = 1'b1;          // read in the wake cycle
    @(negedge clk); stat_rd = 1'b0;
    check("R9 event beats read", ovf, 1);
    after_tick(b + 9);
    stop("R1");

    // 3 * 2^2 = 12 ticks, then deferred change to 2 ticks
    wr(16'hE203);
    start(b);
    exp_q.push_back(b + 12); exp_q.push_back(b + 24);
    exp_q.push_back(b + 26); exp_q.push_back(b + 28);
    after_tick(b + 14);
    wr(16'hE002);
    after_tick(b + 28);
    stop("R5");

    // restart of phase
    wr(16'hE004);
    start(b);
    exp_q.push_back(b + 4);
    wait (tick_n == b + 6);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); run_en = 1'b1; b2 = tick_n;
    exp_q.push_back(b2 + 4);
    after_tick(b2 + 4);
    check("R4 restart phase", wake_seen > 0, 1);
    stop("R4");
    check("R4 rx_en idle", rx_en, 0);

    // zero mantissa
    wr(16'hE200); wr(16'hC803);
    seen = wake_seen;
    start(b);
    after_tick(b + 20);
    check("R6 no wake", wake_seen, seen);
    check("R6 rx_en low", rx_en, 0);
    stop("R6");

    // duty: M=5, R=1, D=1 -> 3 units of 2 ticks
    wr(16'hE105); wr(16'hC803);
    start(b);
    exp_q.push_back(b + 10); exp_q.push_back(b + 20);
    @(negedge clk);
    check("R7 high at period start", rx_en, 1);
    after_tick(b + 5);
    check("R7 high inside on time", rx_en, 1);
    after_tick(b + 6);
    check("R7 low after on time", rx_en, 0);
    after_tick(b + 9);
    check("R7 low until boundary", rx_en, 0);
    after_tick(b + 10);
    check("R7 high in next period", rx_en, 1);
    after_tick(b + 12);
    wr(16'hC802);
    check("R8 duty off forces low", rx_en, 0);
    wr(16'hC807);
    after_tick(b + 16);
    check("R7 full period when 2D+1>=M", rx_en, 1);
    after_tick(b + 20);
    check("R7 high after wrap", rx_en, 1);
    stop("R7");
    check("R4 rx_en low when disabled", rx_en, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule